// File: doc/BRIEF.md
# Reverse Byte Transfer Engine

This block is the peripheral end of a host-paced reverse byte channel on a parallel port. A CPU or DMA feeder writes bytes into a holding register. The block copies each byte into an output register that drives the 8-bit data bus toward the host. It then runs a three-wire handshake with the host: a strobe driven by the peripheral, plus a busy line and a clock line driven by the host. Before each strobe it holds the data stable for a programmable number of system clock cycles.

Two flags pace the feeder. `feed_req_o` asks for the next byte. `idle_o` reports that the host has taken a byte and nothing is waiting to follow it. Separately, the block watches the host's link-active and init lines. It records each edge of those lines in sticky status bits. It also flags an illegal abort when link-active drops outside the legal window, which runs from a host clock rising edge to the next host busy falling edge. Every host input passes through a synchronizer before any decision is made on it.

Top module: `rev_byte_engine`

## Requirements
- R1: Turning `mode_en_i` on raises both `feed_req_o` and `idle_o` within two cycles.
- R2: `data_oe_o` is high when `dir_out_i` is high, and also when the mode is on and the synchronized `link_active_i` is high. In every other case it is low.
- R3: The first write after entry appears on `data_o` after the next clock edge and clears `idle_o`. `feed_req_o` is low for exactly that one cycle and is high again one cycle later.
- R4: `periph_clk_o` falls exactly S+1 cycles after `data_o` takes a new byte, where S is `setup_cyc_i` at the time of the load. S=0 is legal.
- R5: After `periph_clk_o` has fallen and the host raises busy, if no byte is held, `idle_o` goes high and `periph_clk_o` stays low until a write arrives.
- R6: A write while the mode is active clears `feed_req_o` and `idle_o` on the next cycle. Once a byte is held and host busy is high, `periph_clk_o` returns high.
- R7: A held byte moves to `data_o`, with `feed_req_o` set, only after a rising edge of `host_clk_i` followed by host busy being low. A busy-low level seen before that clock edge does not move it.
- R8: Status bit 4 (illegal abort) is set by a falling edge of `link_active_i` outside the window from a `host_clk_i` rising edge to the next `host_busy_i` falling edge. A fall inside that window does not set it.
- R9: Status bits record edges only while the mode is on: bit 0 link-active rise, bit 1 link-active fall, bit 2 init rise, bit 3 init fall.
- R10: Status bits are sticky until cleared by `clr_i` together with a one in the matching position of `clr_bits_i`. Bits with a zero in that position are kept.
- R11: Turning the mode off returns the engine to its initial state: `feed_req_o` and `idle_o` are low and `periph_clk_o` is high. Writes made while the mode is off are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_en_i | input | 1 | Reverse byte mode enable |
| dir_out_i | input | 1 | Port direction setting (1 = drive) used outside the mode |
| setup_cyc_i | input | CNT_W | Data setup time in clock cycles |
| wr_i | input | 1 | Holding register write strobe |
| wr_data_i | input | DATA_W | Byte to write |
| clr_i | input | 1 | Status clear strobe |
| clr_bits_i | input | 5 | Status bits to clear (write one to clear) |
| host_clk_i | input | 1 | Host clock line (asynchronous) |
| host_busy_i | input | 1 | Host busy line (asynchronous) |
| link_active_i | input | 1 | Host link-active line (asynchronous) |
| init_n_i | input | 1 | Host init line, active low (asynchronous) |
| data_o | output | DATA_W | Output register toward the host |
| data_oe_o | output | 1 | Data bus output enable |
| periph_clk_o | output | 1 | Peripheral strobe toward the host |
| feed_req_o | output | 1 | Request for the next byte from the feeder |
| idle_o | output | 1 | Host consumed a byte and none is pending |
| status_o | output | 5 | Sticky edge and illegal-abort flags |

## Verification
The bench builds the engine with its defaults: an 8-bit data path, an 8-bit setup counter and two synchronizer stages. It drives `setup_cyc_i` with 4 and with 0, so both a multi-cycle delay and the shortest possible strobe delay are measured cycle-exactly. With the 8-bit counter, any setup value from 0 to 255 can be reached at runtime without rebuilding. The two-stage synchronizer latency is covered by settling waits, and host edges are placed on both sides of the legal abort window.

// File: rtl/rbe_pkg.sv
package rbe_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_FIRST, ST_SETUP, ST_BUSY_HI, ST_WAIT_DATA, ST_CLK_RISE, ST_BUSY_LO
  } xfer_state_e;

  localparam int HIN_W   = 4;
  localparam int IN_CLK  = 0;
  localparam int IN_BUSY = 1;
  localparam int IN_ACT  = 2;
  localparam int IN_INIT = 3;

  localparam int STAT_W       = 5;
  localparam int SB_ACT_RISE  = 0;
  localparam int SB_ACT_FALL  = 1;
  localparam int SB_INIT_RISE = 2;
  localparam int SB_INIT_FALL = 3;
  localparam int SB_ILLEGAL   = 4;
endpackage

// File: rtl/rbe_sync.sv
module rbe_sync #(
  parameter int                 W       = 4,
  parameter int                 STAGES  = 2,
  parameter logic [W-1:0]       RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign lvl_o[b] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_o;
  end

  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/rbe_status.sv
module rbe_status
  import rbe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_en_i,
  input  logic              act_rise_i,
  input  logic              act_fall_i,
  input  logic              init_rise_i,
  input  logic              init_fall_i,
  input  logic              hclk_rise_i,
  input  logic              busy_fall_i,
  input  logic              clr_i,
  input  logic [STAT_W-1:0] clr_bits_i,
  output logic [STAT_W-1:0] status_o
);
  logic              win_q;
  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] set_vec;

  // window: host clock rise opens, host busy fall closes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          win_q <= 1'b0;
    else if (!mode_en_i)  win_q <= 1'b0;
    else if (hclk_rise_i) win_q <= 1'b1;
    else if (busy_fall_i) win_q <= 1'b0;
  end

  always_comb begin
    set_vec               = '0;
    set_vec[SB_ACT_RISE]  = act_rise_i;
    set_vec[SB_ACT_FALL]  = act_fall_i;
    set_vec[SB_INIT_RISE] = init_rise_i;
    set_vec[SB_INIT_FALL] = init_fall_i;
    set_vec[SB_ILLEGAL]   = act_fall_i & ~win_q;
    if (!mode_en_i) set_vec = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~(clr_i ? clr_bits_i : '0)) | set_vec;
  end

  assign status_o = status_q;

  p_illegal_outside_window_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q[SB_ILLEGAL]) |-> $past(!win_q));

  p_no_flag_when_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_en_i && !clr_i) |=> $stable(status_q));

  p_clear_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && clr_bits_i[SB_INIT_RISE] && !init_rise_i) |=> !status_q[SB_INIT_RISE]);
endmodule

// File: rtl/rbe_xfer.sv
module rbe_xfer
  import rbe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_en_i,
  input  logic [CNT_W-1:0]  setup_cyc_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_lvl_i,
  input  logic              hclk_rise_i,
  output logic [DATA_W-1:0] data_o,
  output logic              periph_clk_o,
  output logic              feed_req_o,
  output logic              idle_o
);
  xfer_state_e       state_q;
  logic [DATA_W-1:0] out_q, hold_q;
  logic              hold_full_q, feed_req_q, idle_q, pclk_q, rearm_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              late_wr;

  assign late_wr = wr_i && (state_q != ST_OFF) && (state_q != ST_FIRST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_OFF;
      out_q       <= '0;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      feed_req_q  <= 1'b0;
      idle_q      <= 1'b0;
      pclk_q      <= 1'b1;
      cnt_q       <= '0;
      rearm_q     <= 1'b0;
    end else if (!mode_en_i) begin
      state_q     <= ST_OFF;
      hold_full_q <= 1'b0;
      feed_req_q  <= 1'b0;
      idle_q      <= 1'b0;
      pclk_q      <= 1'b1;
      rearm_q     <= 1'b0;
    end else begin
      rearm_q <= 1'b0;
      unique case (state_q)
        ST_OFF: begin
          state_q    <= ST_FIRST;
          feed_req_q <= 1'b1;
          idle_q     <= 1'b1;
        end
        ST_FIRST: if (wr_i) begin
          out_q      <= wr_data_i;
          idle_q     <= 1'b0;
          feed_req_q <= 1'b0;
          cnt_q      <= setup_cyc_i;
          rearm_q    <= 1'b1;
          state_q    <= ST_SETUP;
        end
        ST_SETUP: begin
          if (rearm_q) feed_req_q <= 1'b1;  // momentary drop after first byte
          if (cnt_q == '0) begin
            pclk_q  <= 1'b0;
            state_q <= ST_BUSY_HI;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_BUSY_HI: if (busy_lvl_i) begin
          if (hold_full_q) begin
            pclk_q  <= 1'b1;
            state_q <= ST_CLK_RISE;
          end else begin
            idle_q  <= 1'b1;
            state_q <= ST_WAIT_DATA;
          end
        end
        ST_WAIT_DATA: if (hold_full_q) begin
          pclk_q  <= 1'b1;
          state_q <= ST_CLK_RISE;
        end
        ST_CLK_RISE: if (hclk_rise_i) state_q <= ST_BUSY_LO;
        ST_BUSY_LO: if (!busy_lvl_i) begin
          out_q       <= hold_q;
          hold_full_q <= 1'b0;
          feed_req_q  <= 1'b1;
          cnt_q       <= setup_cyc_i;
          state_q     <= ST_SETUP;
        end
        default: state_q <= ST_OFF;
      endcase
      // feeder write overrides flag updates of the same cycle
      if (late_wr) begin
        hold_q      <= wr_data_i;
        hold_full_q <= 1'b1;
        feed_req_q  <= 1'b0;
        idle_q      <= 1'b0;
      end
    end
  end

  assign data_o       = out_q;
  assign periph_clk_o = pclk_q;
  assign feed_req_o   = feed_req_q;
  assign idle_o       = idle_q;

  p_entry_flags_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && mode_en_i) |=> (feed_req_q && idle_q));

  p_first_rearm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_i && mode_en_i && state_q == ST_FIRST) && mode_en_i && !wr_i) |=> feed_req_q);

  p_write_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && mode_en_i && state_q != ST_OFF) |=> (!feed_req_q && !idle_q));

  p_rise_needs_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pclk_q) && $past(mode_en_i)) |-> $past(hold_full_q));

  p_load_sets_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY_LO && !busy_lvl_i && mode_en_i && !wr_i) |=> feed_req_q);

  p_off_returns_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_en_i |=> (state_q == ST_OFF && !feed_req_q && !idle_q && pclk_q));
endmodule

// File: rtl/rev_byte_engine.sv
module rev_byte_engine
  import rbe_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_en_i,
  input  logic              dir_out_i,
  input  logic [CNT_W-1:0]  setup_cyc_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_i,
  input  logic [4:0]        clr_bits_i,
  input  logic              host_clk_i,
  input  logic              host_busy_i,
  input  logic              link_active_i,
  input  logic              init_n_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              periph_clk_o,
  output logic              feed_req_o,
  output logic              idle_o,
  output logic [4:0]        status_o
);
  localparam logic [HIN_W-1:0] HIN_RST = (HIN_W'(1) << IN_CLK) | (HIN_W'(1) << IN_INIT);

  logic [HIN_W-1:0] hin, lvl, rise, fall;
  logic             unused_edges;

  always_comb begin
    hin          = '0;
    hin[IN_CLK]  = host_clk_i;
    hin[IN_BUSY] = host_busy_i;
    hin[IN_ACT]  = link_active_i;
    hin[IN_INIT] = init_n_i;
  end

  rbe_sync #(.W(HIN_W), .STAGES(SYNC_STAGES), .RST_VAL(HIN_RST)) u_sync (
    .clk_i, .rst_ni, .async_i(hin), .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  assign unused_edges = ^{rise[IN_BUSY], fall[IN_CLK], lvl[IN_CLK], lvl[IN_INIT]};

  rbe_xfer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_xfer (
    .clk_i, .rst_ni, .mode_en_i, .setup_cyc_i, .wr_i, .wr_data_i,
    .busy_lvl_i (lvl[IN_BUSY]),
    .hclk_rise_i(rise[IN_CLK]),
    .data_o, .periph_clk_o, .feed_req_o, .idle_o
  );

  rbe_status u_status (
    .clk_i, .rst_ni, .mode_en_i,
    .act_rise_i (rise[IN_ACT]),
    .act_fall_i (fall[IN_ACT]),
    .init_rise_i(rise[IN_INIT]),
    .init_fall_i(fall[IN_INIT]),
    .hclk_rise_i(rise[IN_CLK]),
    .busy_fall_i(fall[IN_BUSY]),
    .clr_i, .clr_bits_i,
    .status_o
  );

  assign data_oe_o = dir_out_i | (mode_en_i & lvl[IN_ACT]);

  p_oe_released_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_out_i && !mode_en_i) |-> !data_oe_o);
endmodule

// File: tb/rev_byte_engine_tb.sv
module rev_byte_engine_tb;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       mode_en, dir_out, wr, clr;
  logic [7:0] setup_cyc, wr_data;
  logic [4:0] clr_bits;
  logic       host_clk, host_busy, link_act, init_n;
  logic [7:0] data;
  logic       data_oe, pclk, feed_req, idle;
  logic [4:0] status;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rev_byte_engine u_dut (
    .clk_i(clk), .rst_ni, .mode_en_i(mode_en), .dir_out_i(dir_out),
    .setup_cyc_i(setup_cyc), .wr_i(wr), .wr_data_i(wr_data),
    .clr_i(clr), .clr_bits_i(clr_bits),
    .host_clk_i(host_clk), .host_busy_i(host_busy),
    .link_active_i(link_act), .init_n_i(init_n),
    .data_o(data), .data_oe_o(data_oe), .periph_clk_o(pclk),
    .feed_req_o(feed_req), .idle_o(idle), .status_o(status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wr_data = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_clear(input logic [4:0] b);
    @(negedge clk); clr = 1'b1; clr_bits = b;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic count_to_strobe(output int k);
    k = 0;
    do begin
      @(negedge clk); k++;
      if (k == 1) check("R3 feed_req back after one cycle", feed_req, 1);
    end while (pclk !== 1'b0 && k < 60);
  endtask

  task automatic t_reset;
    check("R11 reset feed_req", feed_req, 0);
    check("R11 reset idle", idle, 0);
    check("R11 reset periph_clk", pclk, 1);
    check("R10 reset status", status, 0);
    check("R2 reset oe", data_oe, 0);
  endtask

  task automatic t_first_byte;
    int k;
    mode_en = 1'b1; cyc(2);
    check("R1 entry feed_req", feed_req, 1);
    check("R1 entry idle", idle, 1);
    cyc(4);
    check("R2 oe in mode with link active", data_oe, 1);
    do_write(8'hA5);
    check("R3 first byte on bus", data, 8'hA5);
    check("R3 feed_req dropped", feed_req, 0);
    check("R3 idle cleared", idle, 0);
    count_to_strobe(k);
    check("R4 setup delay S=4", k, 5);
  endtask

  task automatic t_stream;
    do_write(8'h5A);
    check("R6 write clears feed_req", feed_req, 0);
    check("R6 write clears idle", idle, 0);
    host_busy = 1'b1; cyc(6);
    check("R6 strobe released with held byte", pclk, 1);
    check("R6 idle stays low", idle, 0);
    host_clk = 1'b0; cyc(4); host_clk = 1'b1; cyc(6);
    check("R7 no transfer while busy high", data, 8'hA5);
    host_busy = 1'b0; cyc(6);
    check("R7 transfer after clk rise and busy low", data, 8'h5A);
    check("R7 feed_req set on transfer", feed_req, 1);
    cyc(10);
    check("R4 strobe low after setup", pclk, 0);
  endtask

  task automatic t_idle_wait;
    host_busy = 1'b1; cyc(6);
    check("R5 idle set with no byte", idle, 1);
    check("R5 feed_req still set", feed_req, 1);
    check("R5 strobe held low", pclk, 0);
    cyc(10);
    check("R5 strobe still low awaiting write", pclk, 0);
    do_write(8'h3C);
    check("R6 late write clears idle", idle, 0);
    check("R6 late write clears feed_req", feed_req, 0);
    cyc(3);
    check("R6 strobe released after late write", pclk, 1);
    host_busy = 1'b0; cyc(8);
    check("R7 busy low without clk rise ignored", data, 8'h5A);
    host_clk = 1'b0; cyc(4); host_clk = 1'b1; cyc(6);
    check("R7 transfer after later clk rise", data, 8'h3C);
  endtask

  task automatic t_abort;
    cyc(12);
    do_clear(5'h1F);
    link_act = 1'b0; cyc(6);
    check("R8 fall inside window not illegal, R9 act fall", status, 5'b00010);
    check("R2 oe low with link inactive", data_oe, 0);
    dir_out = 1'b1; cyc(1);
    check("R2 direction setting drives bus", data_oe, 1);
    dir_out = 1'b0;
    link_act = 1'b1; cyc(6);
    check("R9 act rise", status, 5'b00011);
    host_busy = 1'b1; cyc(6); host_busy = 1'b0; cyc(6);
    link_act = 1'b0; cyc(6);
    check("R8 fall outside window illegal", status, 5'b10011);
    do_clear(5'b00011);
    check("R10 partial clear keeps others", status, 5'b10000);
    do_clear(5'h1F);
    check("R10 full clear", status, 0);
    init_n = 1'b0; cyc(6); init_n = 1'b1; cyc(6);
    check("R9 init edges", status, 5'b01100);
    link_act = 1'b1; cyc(6);
    do_clear(5'h1F);
    check("R10 clear after act rise", status, 0);
  endtask

  task automatic t_exit;
    mode_en = 1'b0; cyc(2);
    check("R11 exit feed_req", feed_req, 0);
    check("R11 exit idle", idle, 0);
    check("R11 exit strobe high", pclk, 1);
    check("R2 exit oe", data_oe, 0);
    do_write(8'h77); cyc(2);
    check("R11 write ignored when off", data, 8'h3C);
    check("R11 feed_req stays low", feed_req, 0);
    init_n = 1'b0; cyc(6); init_n = 1'b1; cyc(6);
    check("R9 no flags when off", status, 0);
  endtask

  task automatic t_zero_setup;
    int k;
    setup_cyc = 8'd0;
    mode_en = 1'b1; cyc(2);
    check("R1 re-entry flags", {feed_req, idle}, 2'b11);
    do_write(8'h81);
    check("R3 first byte after re-entry", data, 8'h81);
    count_to_strobe(k);
    check("R4 setup delay S=0", k, 1);
  endtask

  initial begin
    rst_ni = 1'b0; mode_en = 0; dir_out = 0; setup_cyc = 8'd4;
    wr = 0; wr_data = 0; clr = 0; clr_bits = 0;
    host_clk = 1; host_busy = 0; link_act = 1; init_n = 1;
    cyc(3); rst_ni = 1'b1; cyc(2);
    t_reset;
    t_first_byte;
    t_stream;
    t_idle_wait;
    t_abort;
    t_exit;
    t_zero_setup;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule